// File: doc/BRIEF.md
# Privilege-Aware Register and Memory Access Checker

This block classifies each access a core makes toward two protected targets: a window of 64-bit memory-mapped control registers, and a protected memory region. It decides in the same cycle whether the access goes ahead (allow), traps synchronously (access fault) or raises a bus-error interrupt (bus error). Exactly one of the three result outputs is high for every request. The block is purely combinational and holds no state.

For the register window, two address bits name the lowest privilege allowed to reach a register. The access must have the right shape: 64-bit size, aligned, and a plain load or store. The register must also be listed in a build-time table of implemented addresses. For the memory region, an optional three-zone scheme applies. Zone boundaries are powers of two derived from two size fields. The lowest zone is reserved for machine mode, the middle zone for machine and supervisor, and the rest is open to all modes.

Top module: `access_guard`

## Requirements
- R1: For every request exactly one of res_allow, res_afault, res_berr is high, in the same cycle as the request inputs.
- R2: In the register window, window code req_addr[23:22] = 2'b10 always gives an access fault, from every mode including machine.
- R3: req_mode encodes user 2'b00, supervisor 2'b01, machine 2'b11; the code 2'b10 ranks as user. Window code 00 needs user, 01 needs supervisor, 11 needs machine. A register access whose mode ranks below the code gives an access fault.
- R4: A register access with req_size other than 2'b11 (sizes 0..3 mean 8, 16, 32, 64 bits), or with req_addr[2:0] nonzero, gives an access fault.
- R5: A register access whose req_op is not plain (req_op encodes plain 0, atomic 1, tensor 2, cache maintenance 3) gives an access fault.
- R6: A register access with enough privilege and correct shape gives a bus error when req_addr[23:3] matches no entry of the implemented-register list. This includes a listed offset reached under a different window code.
- R7: A register access with enough privilege and correct shape to an implemented register gives allow.
- R8: When a register access is both unimplemented and faulting for privilege, shape or operation, the result is access fault, never bus error.
- R9: With prot_en low, every memory-region access is allowed for every mode.
- R10: With prot_en high, memory offsets req_addr[23:0] below 4096 << prot_msize are reachable only from machine mode. Supervisor and user get an access fault there.
- R11: With prot_en high, offsets from the machine end up to but not including 4096 << prot_ssize allow machine and supervisor and fault user. If that end is not above the machine end, no supervisor zone exists.
- R12: With prot_en high, offsets at or above both ends are allowed for every mode.
- R13: In the memory region, req_size and req_op have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_is_reg | input | 1 | 1 selects the register window, 0 the protected memory region |
| req_addr | input | 32 | Access address; low 24 bits are the offset within the target |
| req_mode | input | 2 | Current privilege mode of the requester |
| req_size | input | 2 | log2 of access size in bytes |
| req_op | input | 2 | Operation class of the access |
| prot_en | input | 1 | Enables the three-zone memory protection |
| prot_msize | input | 4 | Machine zone end exponent (end = 4096 << value) |
| prot_ssize | input | 4 | Supervisor zone end exponent (end = 4096 << value) |
| res_allow | output | 1 | Access may proceed |
| res_afault | output | 1 | Access fault |
| res_berr | output | 1 | Bus error |

## Verification
The register window is swept over every combination of mode, window code, operation class and size. This is done at implemented offsets, an unlisted aligned offset and a misaligned offset, so that privilege faults, shape faults and missing-register bus errors are told apart. Listed offsets reached under a foreign window code show that a register is matched on its code as well as its offset. The memory region is probed just below and at each zone boundary for several size-field pairs. The pairs include an inverted pair with no supervisor zone and a disabled scheme. Each probe is repeated with odd sizes and operation classes, which shows that those inputs are ignored there.

// File: rtl/acc_chk_pkg.sv
package acc_chk_pkg;

  typedef enum logic [1:0] {
    MODE_U   = 2'b00,
    MODE_S   = 2'b01,
    MODE_RSV = 2'b10,
    MODE_M   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    OP_PLAIN  = 2'd0,
    OP_ATOMIC = 2'd1,
    OP_TENSOR = 2'd2,
    OP_CACHE  = 2'd3
  } op_e;

  localparam logic [1:0] SIZE_DWORD = 2'd3;

  // Rank: user 0, supervisor 1, machine 2; the unused code ranks as user.
  function automatic logic [1:0] mode_rank(input logic [1:0] m);
    case (m)
      MODE_S:  mode_rank = 2'd1;
      MODE_M:  mode_rank = 2'd2;
      default: mode_rank = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/reg_window_dec.sv
module reg_window_dec
  import acc_chk_pkg::*;
#(
  parameter int                          REG_OFF_W = 24,
  parameter int                          NUM_REGS  = 4,
  parameter logic [NUM_REGS*REG_OFF_W-1:0] REG_LIST  = '0
) (
  input  logic [REG_OFF_W-1:0] offs,
  input  logic [1:0]           mode,
  input  logic [1:0]           size,
  input  logic [1:0]           op,
  output logic                 rw_afault,
  output logic                 rw_berr
);

  localparam int IDX_W = REG_OFF_W - 3;

  logic [NUM_REGS-1:0] hit_vec;
  logic                hit;
  logic [1:0]          code;
  logic [1:0]          need;
  logic                rsv;
  logic                priv_ok;
  logic                shape_ok;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_match
    assign hit_vec[i] = (offs[REG_OFF_W-1:3] == REG_LIST[i*REG_OFF_W+3 +: IDX_W]);
  end

  assign hit = |hit_vec;

  always_comb begin
    code     = offs[REG_OFF_W-1 -: 2];
    rsv      = (code == 2'b10);
    need     = (code == 2'b11) ? 2'd2 : ((code == 2'b01) ? 2'd1 : 2'd0);
    priv_ok  = !rsv && (mode_rank(mode) >= need);
    shape_ok = (size == SIZE_DWORD) && (offs[2:0] == 3'b000) && (op == OP_PLAIN);
    rw_afault = !(priv_ok && shape_ok);
    rw_berr   = !rw_afault && !hit;
  end

  always_comb begin
    // R2
    rsv_code_chk: assert (!(code == 2'b10) || (rw_afault && !rw_berr));
    // R5
    op_class_chk: assert ((op == OP_PLAIN) || rw_afault);
    // R3
    user_reach_chk: assert (!(mode_rank(mode) == 2'd0 && code != 2'b00) || rw_afault);
  end

endmodule

// File: rtl/mem_zone_prot.sv
module mem_zone_prot
  import acc_chk_pkg::*;
#(
  parameter int MEM_OFF_W = 24,
  parameter int SIZE_W    = 4
) (
  input  logic [MEM_OFF_W-1:0] offs,
  input  logic [1:0]           mode,
  input  logic                 prot_en,
  input  logic [SIZE_W-1:0]    msize,
  input  logic [SIZE_W-1:0]    ssize,
  output logic                 mz_afault
);

  localparam int SHIFT_W = 13 + (1 << SIZE_W);
  localparam int BOUND_W = (SHIFT_W > MEM_OFF_W) ? SHIFT_W : MEM_OFF_W;
  localparam logic [BOUND_W-1:0] ZONE_UNIT = BOUND_W'(4096);

  logic [BOUND_W-1:0] off_x;
  logic [BOUND_W-1:0] m_end;
  logic [BOUND_W-1:0] s_end;
  logic               in_m;
  logic               in_s;
  logic [1:0]         need;

  always_comb begin
    off_x = BOUND_W'(offs);
    m_end = ZONE_UNIT << msize;
    s_end = ZONE_UNIT << ssize;
    in_m  = (off_x < m_end);
    in_s  = !in_m && (off_x < s_end);
    need  = in_m ? 2'd2 : (in_s ? 2'd1 : 2'd0);
    mz_afault = prot_en && (mode_rank(mode) < need);
  end

  always_comb begin
    // R9
    no_prot_chk: assert (prot_en || !mz_afault);
    // R10
    mach_mem_chk: assert (!(mode == MODE_M) || !mz_afault);
  end

endmodule

// File: rtl/verdict_merge.sv
module verdict_merge (
  input  logic sel_reg,
  input  logic rw_afault,
  input  logic rw_berr,
  input  logic mz_afault,
  output logic res_allow,
  output logic res_afault,
  output logic res_berr
);

  always_comb begin
    if (sel_reg) begin
      res_afault = rw_afault;
      res_berr   = rw_berr && !rw_afault;
    end else begin
      res_afault = mz_afault;
      res_berr   = 1'b0;
    end
    res_allow = !res_afault && !res_berr;
  end

endmodule

// File: rtl/access_guard.sv
module access_guard
  import acc_chk_pkg::*;
#(
  parameter int                            ADDR_W    = 32,
  parameter int                            REG_OFF_W = 24,
  parameter int                            MEM_OFF_W = 24,
  parameter int                            SIZE_W    = 4,
  parameter int                            NUM_REGS  = 4,
  parameter logic [NUM_REGS*REG_OFF_W-1:0] REG_LIST  =
    {24'hC00018, 24'hC00010, 24'h400008, 24'h000000}
) (
  input  logic              req_is_reg,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_mode,
  input  logic [1:0]        req_size,
  input  logic [1:0]        req_op,
  input  logic              prot_en,
  input  logic [SIZE_W-1:0] prot_msize,
  input  logic [SIZE_W-1:0] prot_ssize,
  output logic              res_allow,
  output logic              res_afault,
  output logic              res_berr
);

  logic rw_afault;
  logic rw_berr;
  logic mz_afault;

  reg_window_dec #(
    .REG_OFF_W (REG_OFF_W),
    .NUM_REGS  (NUM_REGS),
    .REG_LIST  (REG_LIST)
  ) u_reg (
    .offs      (req_addr[REG_OFF_W-1:0]),
    .mode      (req_mode),
    .size      (req_size),
    .op        (req_op),
    .rw_afault (rw_afault),
    .rw_berr   (rw_berr)
  );

  mem_zone_prot #(
    .MEM_OFF_W (MEM_OFF_W),
    .SIZE_W    (SIZE_W)
  ) u_mem (
    .offs      (req_addr[MEM_OFF_W-1:0]),
    .mode      (req_mode),
    .prot_en   (prot_en),
    .msize     (prot_msize),
    .ssize     (prot_ssize),
    .mz_afault (mz_afault)
  );

  verdict_merge u_merge (
    .sel_reg    (req_is_reg),
    .rw_afault  (rw_afault),
    .rw_berr    (rw_berr),
    .mz_afault  (mz_afault),
    .res_allow  (res_allow),
    .res_afault (res_afault),
    .res_berr   (res_berr)
  );

  always_comb begin
    // R1
    onehot_chk: assert ($onehot({res_allow, res_afault, res_berr}));
    // R8
    fault_first_chk: assert (!(req_is_reg && rw_afault) || !res_berr);
    // R13
    mem_no_berr_chk: assert (req_is_reg || !res_berr);
  end

endmodule

// File: tb/tb_access_guard.sv
module tb_access_guard;

  localparam logic [4*24-1:0] TB_LIST = {24'hC00018, 24'hC00010, 24'h400008, 24'h000000};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_is_reg;
  logic [31:0] req_addr;
  logic [1:0]  req_mode;
  logic [1:0]  req_size;
  logic [1:0]  req_op;
  logic        prot_en;
  logic [3:0]  prot_msize;
  logic [3:0]  prot_ssize;
  logic        res_allow;
  logic        res_afault;
  logic        res_berr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  access_guard #(.NUM_REGS(4), .REG_LIST(TB_LIST)) dut (
    .req_is_reg (req_is_reg),
    .req_addr   (req_addr),
    .req_mode   (req_mode),
    .req_size   (req_size),
    .req_op     (req_op),
    .prot_en    (prot_en),
    .prot_msize (prot_msize),
    .prot_ssize (prot_ssize),
    .res_allow  (res_allow),
    .res_afault (res_afault),
    .res_berr   (res_berr)
  );

  // Expected result: 0 allow, 1 access fault, 2 bus error
  function automatic int rank_of(input logic [1:0] m);
    if (m == 2'b01) return 1;
    if (m == 2'b11) return 2;
    return 0;
  endfunction

  function automatic int need_of(input logic [1:0] c);
    if (c == 2'b11) return 2;
    if (c == 2'b01) return 1;
    return 0;
  endfunction

  function automatic bit listed(input logic [23:0] a);
    for (int i = 0; i < 4; i++)
      if (a[23:3] == TB_LIST[i*24+3 +: 21]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int exp_reg(input logic [23:0] a, input logic [1:0] m,
                                 input logic [1:0] s, input logic [1:0] o);
    if (a[23:22] == 2'b10) return 1;
    if (rank_of(m) < need_of(a[23:22])) return 1;
    if (s != 2'd3 || a[2:0] != 3'd0 || o != 2'd0) return 1;
    if (!listed(a)) return 2;
    return 0;
  endfunction

  function automatic string tag_reg(input logic [23:0] a, input logic [1:0] m,
                                    input logic [1:0] s, input logic [1:0] o);
    if (a[23:22] == 2'b10) return "R2";
    if (rank_of(m) < need_of(a[23:22])) return "R3";
    if (s != 2'd3 || a[2:0] != 3'd0) return "R4";
    if (o != 2'd0) return "R5";
    if (!listed(a)) return "R6";
    return "R7";
  endfunction

  function automatic int exp_mem(input logic [23:0] a, input logic [1:0] m,
                                 input bit en, input logic [3:0] ms, input logic [3:0] ss);
    longint me, se, off;
    int need;
    if (!en) return 0;
    me = longint'(4096) << ms;
    se = longint'(4096) << ss;
    off = longint'(a);
    if (off < me) need = 2;
    else if (off < se) need = 1;
    else need = 0;
    return (rank_of(m) < need) ? 1 : 0;
  endfunction

  function automatic string tag_mem(input logic [23:0] a, input bit en,
                                    input logic [3:0] ms, input logic [3:0] ss);
    longint me, se;
    if (!en) return "R9";
    me = longint'(4096) << ms;
    se = longint'(4096) << ss;
    if (longint'(a) < me) return "R10";
    if (longint'(a) < se) return "R11";
    return "R12";
  endfunction

  task automatic compare(input string tag, input int exp);
    logic [2:0] got;
    logic [2:0] want;
    #1;
    got  = {res_berr, res_afault, res_allow};
    want = (exp == 0) ? 3'b001 : ((exp == 1) ? 3'b010 : 3'b100);
    checks++;
    if (got != want) begin
      errors++;
      $display("FAIL %s: addr=%h mode=%0d size=%0d op=%0d en=%0b ms=%0d ss=%0d got {berr,af,ok}=%b expected %b",
               tag, req_addr, req_mode, req_size, req_op, prot_en, prot_msize, prot_ssize, got, want);
    end
    checks++;
    if (!$onehot(got)) begin
      errors++;
      $display("FAIL R1: result not one-hot, got %b expected one-hot", got);
    end
    #1;
  endtask

  task automatic drive(input bit isr, input logic [31:0] a, input logic [1:0] m,
                       input logic [1:0] s, input logic [1:0] o);
    req_is_reg = isr; req_addr = a; req_mode = m; req_size = s; req_op = o;
  endtask

  // Idle state: all inputs zero, memory region, protection off -> allow (R9)
  task automatic t_idle();
    req_is_reg = 1'b0; req_addr = '0; req_mode = '0; req_size = '0; req_op = '0;
    prot_en = 1'b0; prot_msize = '0; prot_ssize = '0;
    compare("R9", 0);
  endtask

  // Full register sweep: R2 R3 R4 R5 R6 R7
  task automatic t_reg_sweep();
    logic [21:0] lows [6];
    lows[0] = 22'h000000; lows[1] = 22'h000008; lows[2] = 22'h000010;
    lows[3] = 22'h000018; lows[4] = 22'h000100; lows[5] = 22'h000004;
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 4; c++)
        for (int o = 0; o < 4; o++)
          for (int s = 0; s < 4; s++)
            for (int k = 0; k < 6; k++) begin
              logic [23:0] a;
              a = {c[1:0], lows[k]};
              drive(1'b1, {8'h80, a}, m[1:0], s[1:0], o[1:0]);
              compare(tag_reg(a, m[1:0], s[1:0], o[1:0]),
                      exp_reg(a, m[1:0], s[1:0], o[1:0]));
            end
  endtask

  // Listed offsets under a foreign code, machine mode: R6
  task automatic t_wrong_window();
    drive(1'b1, 32'h8040_0000, 2'b11, 2'd3, 2'd0); compare("R6", 2);
    drive(1'b1, 32'h80C0_0008, 2'b11, 2'd3, 2'd0); compare("R6", 2);
    drive(1'b1, 32'h8000_0010, 2'b11, 2'd3, 2'd0); compare("R6", 2);
    drive(1'b1, 32'h80C0_0010, 2'b11, 2'd3, 2'd0); compare("R7", 0);
  endtask

  // Unlisted plus faulting: fault wins (R8)
  task automatic t_precedence();
    drive(1'b1, 32'h8000_0100, 2'b11, 2'd2, 2'd0); compare("R8", 1);
    drive(1'b1, 32'h80C0_0100, 2'b01, 2'd3, 2'd0); compare("R8", 1);
    drive(1'b1, 32'h8000_0100, 2'b00, 2'd3, 2'd1); compare("R8", 1);
    drive(1'b1, 32'h8080_0100, 2'b11, 2'd3, 2'd0); compare("R8", 1);
  endtask

  // Memory zones, boundaries, ignored size/op: R9 R10 R11 R12 R13
  task automatic t_mem_zones();
    logic [3:0] ms_set [5];
    logic [3:0] ss_set [5];
    ms_set[0] = 4'd0; ss_set[0] = 4'd2;
    ms_set[1] = 4'd3; ss_set[1] = 4'd7;
    ms_set[2] = 4'd5; ss_set[2] = 4'd2;
    ms_set[3] = 4'd4; ss_set[3] = 4'd4;
    ms_set[4] = 4'd1; ss_set[4] = 4'd15;
    for (int en = 0; en < 2; en++)
      for (int p = 0; p < 5; p++) begin
        longint me, se;
        logic [23:0] pts [7];
        prot_en = en[0]; prot_msize = ms_set[p]; prot_ssize = ss_set[p];
        me = longint'(4096) << ms_set[p];
        se = longint'(4096) << ss_set[p];
        pts[0] = 24'h0;
        pts[1] = 24'(me - 1); pts[2] = 24'(me);
        pts[3] = (se > 24'hFFFFFF) ? 24'hFFFFF0 : 24'(se - 1);
        pts[4] = (se > 24'hFFFFFF) ? 24'hFFFFFF : 24'(se);
        pts[5] = 24'hFFFFFF; pts[6] = 24'(me + 8);
        for (int k = 0; k < 7; k++)
          for (int m = 0; m < 4; m++) begin
            int e;
            e = exp_mem(pts[k], m[1:0], en[0], ms_set[p], ss_set[p]);
            drive(1'b0, {8'h40, pts[k]}, m[1:0], 2'd3, 2'd0);
            compare(tag_mem(pts[k], en[0], ms_set[p], ss_set[p]), e);
            // R13: odd size and op class leave the verdict unchanged
            drive(1'b0, {8'h40, pts[k]}, m[1:0], 2'(k), 2'(m + k + 1));
            compare("R13", e);
          end
      end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1: watchdog expired, got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_idle();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_idle();
    t_reg_sweep();
    t_wrong_window();
    t_precedence();
    t_mem_zones();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule